// File: doc/BRIEF.md
# Dual-Channel Gated Tone Generator

This block produces a square-wave signalling tone for each of two supply channels. A free-running prescaler turns the fast system clock into the converter clock tick. One shared divider splits that tick by ten, so the tone runs at one tenth of the converter rate: 22 kHz for a 220 kHz converter. Because both channels use the same divider, their tones are always phase aligned.

Each channel picks whether its tone is silent, follows a burst pin, or runs without a break. This is set by a per-channel continuous-tone bit, a per-channel burst pin and a per-channel channel-enable. The burst pin is synchronized and is meant for fast on/off keying of the tone, which allows burst-coded command signalling. The outputs are logic-level modulation strobes. Wave shaping and injection into the output regulator happen downstream.

Each channel has a three-state gate machine:
- **GATE_IDLE**: tone masked.
- **GATE_BURST**: tone follows the pin.
- **GATE_CONT**: tone held on by the register bit.

The transitions are the same from every state, and they are taken in priority order:
- **to_idle_disabled**: the channel-enable is low.
- **to_cont**: the continuous bit is high.
- **to_burst**: the synchronized pin is high.
- **to_idle_quiet**: otherwise.

Top module: `tone_gen_dual`

## Requirements
- R1: `conv_tick` is a single-clock pulse that repeats exactly every PRESCALE clock cycles (default 4).
- R2: An active tone is symmetrical, with a period of DIV converter ticks (default 10). It is high for the first DIV/2 ticks of the divider count and low for the remaining DIV/2 ticks. With the defaults this is 20 clocks high and 20 clocks low.
- R3: When a channel is enabled and its continuous bit is 1, its tone runs continuously whatever level its burst pin has.
- R4: When the continuous bit is 0, a high burst pin turns the channel's tone on. A low burst pin keeps the channel's output at 0.
- R5: When a channel-enable is 0, that channel's output is 0 from the second clock edge after the enable falls, even if the continuous bit is 1.
- R6: The burst pin passes through a two-flop synchronizer. The output is 0 by the fourth clock edge after the pin falls. After the pin rises, the output goes high within 4 + DIV×PRESCALE clocks.
- R7: The two channels are gated independently. Activity on one channel's bit or pin never changes the other channel's output or its period.
- R8: All active channels share one divider, so their outputs are identical cycle for cycle. Gating a channel on or off never restarts the divider.
- R9: Reset is synchronous and active high. While reset is held, both outputs and `conv_tick` are 0. After release, the divider restarts at the beginning of its high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| cont_bit | input | NCH | Per-channel continuous-tone bit |
| burst_pin | input | NCH | Per-channel asynchronous burst gating pin |
| chan_en | input | NCH | Per-channel enable |
| tone_out | output | NCH | Per-channel tone modulation strobe |
| conv_tick | output | 1 | Converter clock tick, one clock wide |

## Verification
On every cycle, the assertions check four things:
- an output is only high during the divider's high half;
- a disabled channel goes silent two edges after its enable falls;
- a continuously enabled channel tracks the divider exactly;
- the tick never lasts two cycles and the divider count stays in range.

The bench scenarios are the only way to show several other behaviours. These are the measured high and low run lengths, the priority of the continuous bit over the pin, and the bounded on and off response to pin edges. They also include the cycle-by-cycle phase match between channels while the other channel is being keyed, and the restart phase after reset.

// File: rtl/tone_gen_pkg.sv
package tone_gen_pkg;
    typedef enum logic [1:0] {
        GATE_IDLE  = 2'd0,
        GATE_BURST = 2'd1,
        GATE_CONT  = 2'd2
    } gate_state_t;
endpackage

// File: rtl/tone_tick_prescaler.sv
module tone_tick_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE == 1) begin : g_pass
            assign tick = !rst;
        end else begin : g_count
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pcnt <= '0;
                end else if (pcnt == LAST) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end

            assign tick = (pcnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/tone_phase_divider.sv
module tone_phase_divider #(
    parameter int DIV = 10,
    localparam int CW = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    output logic          high_half,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick) begin
            if (count == LAST) begin
                count <= '0;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    assign high_half = (count < HALF);
endmodule

// File: rtl/tone_pin_sync.sv
module tone_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tone_gate_fsm.sv
module tone_gate_fsm
    import tone_gen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic cont_req,
    input  logic pin_s,
    input  logic phase_high,
    output logic tone
);
    gate_state_t state, state_nx;

    // Priority: disable, then continuous bit, then burst pin.
    function automatic gate_state_t pick(input logic e, input logic c, input logic p);
        if (!e)     return GATE_IDLE;   // to_idle_disabled
        else if (c) return GATE_CONT;   // to_cont
        else if (p) return GATE_BURST;  // to_burst
        else        return GATE_IDLE;   // to_idle_quiet
    endfunction

    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_IDLE:  state_nx = pick(en, cont_req, pin_s);
            GATE_BURST: state_nx = pick(en, cont_req, pin_s);
            GATE_CONT:  state_nx = pick(en, cont_req, pin_s);
            default:    state_nx = GATE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= GATE_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tone <= 1'b0;
        end else begin
            unique case (state)
                GATE_IDLE:  tone <= 1'b0;
                GATE_BURST: tone <= phase_high;
                GATE_CONT:  tone <= phase_high;
                default:    tone <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tone_gen_dual.sv
module tone_gen_dual #(
    parameter int NCH         = 2,
    parameter int DIV         = 10,
    parameter int PRESCALE    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] cont_bit,
    input  logic [NCH-1:0] burst_pin,
    input  logic [NCH-1:0] chan_en,
    output logic [NCH-1:0] tone_out,
    output logic           conv_tick
);
    localparam int CW = $clog2(DIV);

    logic          div_high;
    logic [CW-1:0] div_cnt;
    logic [NCH-1:0] pin_sync;

    tone_tick_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (conv_tick)
    );

    tone_phase_divider #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .tick      (conv_tick),
        .high_half (div_high),
        .count     (div_cnt)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            tone_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .d   (burst_pin[c]),
                .q   (pin_sync[c])
            );

            tone_gate_fsm u_gate (
                .clk        (clk),
                .rst        (rst),
                .en         (chan_en[c]),
                .cont_req   (cont_bit[c]),
                .pin_s      (pin_sync[c]),
                .phase_high (div_high),
                .tone       (tone_out[c])
            );
        end
    endgenerate
endmodule

// File: rtl/tone_gen_dual_chk.sv
module tone_gen_dual_chk #(
    parameter int NCH      = 2,
    parameter int DIV      = 10,
    parameter int PRESCALE = 4,
    localparam int CW = $clog2(DIV)
) (
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] cont_bit,
    input logic [NCH-1:0] chan_en,
    input logic [NCH-1:0] tone_out,
    input logic           conv_tick,
    input logic           div_high,
    input logic [CW-1:0]  div_cnt
);
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        div_cnt < CW'(DIV)); // R2

    generate
        if (PRESCALE > 1) begin : g_tick
            AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
                conv_tick |=> !conv_tick); // R1
        end
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            AST_TONE_HIGH_HALF: assert property (@(posedge clk) disable iff (rst)
                tone_out[c] |-> $past(div_high)); // R2
            AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
                !chan_en[c] |-> ##2 !tone_out[c]); // R5
            AST_CONT_TRACKS: assert property (@(posedge clk) disable iff (rst)
                (chan_en[c] && cont_bit[c] && $past(chan_en[c] && cont_bit[c]) && !$past(rst))
                |=> (tone_out[c] == $past(div_high))); // R3
        end
    endgenerate
endmodule

bind tone_gen_dual tone_gen_dual_chk #(.NCH(NCH), .DIV(DIV), .PRESCALE(PRESCALE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cont_bit  (cont_bit),
    .chan_en   (chan_en),
    .tone_out  (tone_out),
    .conv_tick (conv_tick),
    .div_high  (div_high),
    .div_cnt   (div_cnt)
);

// File: tb/sim_tone_gen_dual.sv
module sim_tone_gen_dual;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int DIV = 10;
    localparam int PRESCALE = 4;
    localparam int HALF_CLKS = (DIV / 2) * PRESCALE;
    localparam int PERIOD_CLKS = DIV * PRESCALE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0] cont_bit = '0;
    logic [NCH-1:0] burst_pin = '0;
    logic [NCH-1:0] chan_en = '0;
    logic [NCH-1:0] tone_out;
    logic conv_tick;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tone_gen_dual #(.NCH(NCH), .DIV(DIV), .PRESCALE(PRESCALE)) u0 (
        .clk(clk), .rst(rst), .cont_bit(cont_bit), .burst_pin(burst_pin),
        .chan_en(chan_en), .tone_out(tone_out), .conv_tick(conv_tick)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Measure one full high run and the following low run of a channel.
    task automatic runs(input int ch, output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        while (tone_out[ch] && guard < 4*PERIOD_CLKS) begin step(1); guard++; end
        while (!tone_out[ch] && guard < 4*PERIOD_CLKS) begin step(1); guard++; end
        while (tone_out[ch] && guard < 4*PERIOD_CLKS) begin step(1); hi++; guard++; end
        while (!tone_out[ch] && guard < 4*PERIOD_CLKS) begin step(1); lo++; guard++; end
    endtask

    task automatic t_reset();
        rst = 1'b1; chan_en = '1; cont_bit = '1;
        step(3);
        chk(tone_out == '0, "R9", "outputs in reset", int'(tone_out), 0);
        chk(conv_tick == 1'b0, "R9", "tick in reset", int'(conv_tick), 0);
        rst = 1'b0;
        step(2);
        chk(tone_out == '1, "R9", "divider restarts in high half", int'(tone_out), 3);
        chan_en = '0; cont_bit = '0;
        step(4);
    endtask

    task automatic t_tick();
        int gap;
        while (!conv_tick) step(1);
        for (int k = 0; k < 3; k++) begin
            gap = 0;
            step(1); gap++;
            while (!conv_tick && gap < 100) begin step(1); gap++; end
            chk(gap == PRESCALE, "R1", "tick spacing", gap, PRESCALE);
        end
    endtask

    task automatic t_continuous();
        int hi, lo;
        chan_en = 2'b01; cont_bit = 2'b01; burst_pin = 2'b00;
        step(6);
        runs(0, hi, lo);
        chk(hi == HALF_CLKS, "R2", "continuous high run", hi, HALF_CLKS);
        chk(lo == HALF_CLKS, "R2", "continuous low run", lo, HALF_CLKS);
        burst_pin = 2'b01; step(6); burst_pin = 2'b00; step(6);
        runs(0, hi, lo);
        chk(hi == HALF_CLKS && lo == HALF_CLKS, "R3", "continuous bit overrides pin", hi + lo, PERIOD_CLKS);
        cont_bit = '0; step(6);
    endtask

    task automatic t_burst();
        int hi, lo, seen, wait_n;
        chan_en = 2'b01; cont_bit = '0; burst_pin = '0;
        seen = 0;
        for (int i = 0; i < 2*PERIOD_CLKS; i++) begin step(1); if (tone_out[0]) seen++; end
        chk(seen == 0, "R4", "pin low keeps output off", seen, 0);
        burst_pin = 2'b01;
        wait_n = 0;
        while (!tone_out[0] && wait_n < 4 + PERIOD_CLKS + 5) begin step(1); wait_n++; end
        chk(tone_out[0] && wait_n <= 4 + PERIOD_CLKS, "R6", "tone starts after pin rise", wait_n, 4 + PERIOD_CLKS);
        runs(0, hi, lo);
        chk(hi == HALF_CLKS && lo == HALF_CLKS, "R4", "pin-gated tone period", hi + lo, PERIOD_CLKS);
        while (!tone_out[0]) step(1);
        burst_pin = 2'b00;
        step(4);
        chk(tone_out[0] == 1'b0, "R6", "off four edges after pin fall", int'(tone_out[0]), 0);
        seen = 0;
        for (int i = 0; i < 2*PERIOD_CLKS; i++) begin step(1); if (tone_out[0]) seen++; end
        chk(seen == 0, "R6", "stays off after pin fall", seen, 0);
    endtask

    task automatic t_disable();
        int seen = 0;
        chan_en = 2'b01; cont_bit = 2'b01;
        step(4);
        while (!tone_out[0]) step(1);
        chan_en = 2'b00;
        step(2);
        chk(tone_out[0] == 1'b0, "R5", "disable silences in two edges", int'(tone_out[0]), 0);
        for (int i = 0; i < PERIOD_CLKS; i++) begin step(1); if (tone_out[0]) seen++; end
        chk(seen == 0, "R5", "disabled with continuous bit", seen, 0);
        cont_bit = '0;
    endtask

    task automatic t_independent();
        int hi, lo, seen = 0;
        chan_en = 2'b11; cont_bit = 2'b01; burst_pin = 2'b00;
        step(6);
        for (int i = 0; i < 2*PERIOD_CLKS; i++) begin step(1); if (tone_out[1]) seen++; end
        chk(seen == 0, "R7", "idle channel unaffected by neighbour", seen, 0);
        cont_bit = 2'b10; burst_pin = 2'b01; step(6);
        runs(0, hi, lo);
        chk(hi + lo == PERIOD_CLKS, "R7", "channel 0 period with channel 1 continuous", hi + lo, PERIOD_CLKS);
        cont_bit = '0; burst_pin = '0; chan_en = '0; step(6);
    endtask

    task automatic t_align();
        int hi, lo, mism = 0;
        chan_en = 2'b11; cont_bit = 2'b01; burst_pin = 2'b00;
        step(7);
        burst_pin = 2'b10; step(6);
        for (int i = 0; i < 3*PERIOD_CLKS; i++) begin step(1); if (tone_out[0] != tone_out[1]) mism++; end
        chk(mism == 0, "R8", "channels phase aligned", mism, 0);
        fork
            begin
                for (int k = 0; k < 6; k++) begin burst_pin[1] = ~burst_pin[1]; step(7); end
            end
            begin
                runs(0, hi, lo);
            end
        join
        chk(hi == HALF_CLKS && lo == HALF_CLKS, "R8", "gating does not restart divider", hi + lo, PERIOD_CLKS);
        burst_pin = 2'b10; step(6);
        mism = 0;
        for (int i = 0; i < PERIOD_CLKS; i++) begin step(1); if (tone_out[0] != tone_out[1]) mism++; end
        chk(mism == 0, "R8", "alignment after re-gating", mism, 0);
        chan_en = '0; cont_bit = '0; burst_pin = '0; step(4);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(1);
        t_reset();
        t_tick();
        t_continuous();
        t_burst();
        t_disable();
        t_independent();
        t_align();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule